// File: doc/BRIEF.md
# DMA Address Translation Table Lookup

This block turns I/O-virtual DMA addresses into physical addresses by indexing a flat, single-level table of 64-bit translation entries kept in local RAM. A requester presents an address together with the kind of access it wants (read, write or both). The block subtracts the configured bus-window base and divides by the page size to pick one entry. It then returns the page-aligned I/O address, the physical page address, the page-offset mask, the two-bit permission code held in the entry and a flag that says whether the requested access is permitted.

The page shift, the number of live entries and the bus-window base are run-time configuration inputs. They are sampled together with the request. An entry count of zero disables the table. An address that falls outside the window produces a no-access response with an all-ones mask instead of an error. A plain write port lets the surrounding logic place entries in the RAM. The lookup has two register stages: the RAM read, then the result register. A valid strobe marks each response.

Top module: `dma_xlate_lookup`

## Requirements
- R1: While rst_n is low at a rising edge, and after it, until a request has completed, rsp_valid is 0 and every response data output is 0.
- R2: A request sampled with req_valid high at rising edge k yields exactly one response with rsp_valid high after edge k+2. Back-to-back requests give back-to-back responses in order, and a cycle without a request gives rsp_valid low two edges later.
- R3: The entry index is (req_addr - cfg_window_base) >> cfg_page_shift. For an in-window hit, rsp_xaddr is that entry with its low cfg_page_shift bits cleared, for every shift value used (12, 16 and 21 are tried).
- R4: On a hit, rsp_iova is req_addr with its low cfg_page_shift bits cleared, and rsp_mask is (1 << cfg_page_shift) - 1.
- R5: On a hit, rsp_perm equals bits [1:0] of the entry, coded as 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R6: req_acc bit 0 requests a read and bit 1 requests a write. rsp_allow is 1 only on a hit where req_acc is non-zero and every requested bit is also set in rsp_perm. req_acc = 0 gives rsp_allow = 0.
- R7: When the address is below cfg_window_base or the index is not less than cfg_entry_count, the response has rsp_perm = 0, rsp_iova = 0, rsp_xaddr = 0, rsp_mask all ones and rsp_allow = 0.
- R8: When cfg_entry_count is 0, every lookup reports the no-access response of R7.
- R9: A write with tbl_we high stores tbl_wdata at index tbl_widx. A later lookup of that index uses the new value, and a second write to the same index replaces the first.
- R10: An index of DEPTH or more is out of window even when cfg_entry_count exceeds DEPTH, while indices below DEPTH are looked up normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_page_shift | input | 6 | log2 of the page size |
| cfg_entry_count | input | 9 | Number of live table entries; 0 disables the table |
| cfg_window_base | input | 64 | Lowest bus address covered by the table |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | 8 | Table write index |
| tbl_wdata | input | 64 | Table write data (page frame plus permission code in bits 1:0) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | I/O-virtual address to translate |
| req_acc | input | 2 | Requested access: bit 0 read, bit 1 write |
| rsp_valid | output | 1 | Response strobe |
| rsp_iova | output | 64 | Page-aligned request address, 0 on a miss |
| rsp_xaddr | output | 64 | Translated page address, 0 on a miss |
| rsp_mask | output | 64 | Page-offset mask, all ones on a miss |
| rsp_perm | output | 2 | Permission code of the entry, 0 on a miss |
| rsp_allow | output | 1 | Requested access is permitted |

## Verification
The lookup is run with the four permission codes crossed with read, write, read-and-write and empty access requests. This separates a wrong permission decode from a wrong coverage test. Addresses at the first and last live index, one past the last index, below a non-zero window base, and beyond the RAM depth with an oversized count separate the bound checks from the index arithmetic. The page shifts 12, 16 and 21 each need a different slice of the address and entry, together with table entries that carry junk in their offset bits, so a fixed or misplaced mask shows up. Directed sequences cover back-to-back timing, a disabled table and the overwrite of a live entry.

// File: rtl/dma_xlate_pkg.sv
// Shared types for the DMA translation lookup.
// Assumes: the permission code sits in bits [1:0] of every table entry.
package dma_xlate_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    // Request coding: bit 0 read, bit 1 write.
    localparam logic [1:0] ACC_RD = 2'b01;
    localparam logic [1:0] ACC_WR = 2'b10;

    // True when a non-empty request is fully covered by the permission code.
    function automatic logic acc_covered(input logic [1:0] acc, input perm_e perm);
        return (acc != 2'b00) && ((acc & ~perm) == 2'b00);
    endfunction

endpackage

// File: rtl/dma_xlate_index.sv
// Window and index calculation for one lookup (combinational).
// Works out the page mask and the entry index from the request address,
// and decides whether the address lies inside the live part of the table.
// Assumes: shift < ADDR_W; the configuration is stable while a request is sampled.
module dma_xlate_index #(
    parameter int ADDR_W  = 64,
    parameter int DEPTH   = 256,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  win_base,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [CNT_W-1:0]   entry_count,
    output logic [IDX_W-1:0]   idx,
    output logic               in_window,
    output logic [ADDR_W-1:0]  page_mask
);

    localparam logic [ADDR_W-1:0] DEPTH_W = ADDR_W'(DEPTH);

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] full_idx;
    logic              below_base;
    logic              under_count;
    logic              under_depth;

    // Page mask: ones above the page-offset bits.
    always_comb begin
        page_mask = ~((ADDR_W'(1) << page_shift) - ADDR_W'(1));
    end

    // Window-relative index and the three bound tests.
    always_comb begin
        offs        = addr - win_base;
        below_base  = addr < win_base;
        full_idx    = offs >> page_shift;
        under_count = full_idx < ADDR_W'(entry_count);
        under_depth = full_idx < DEPTH_W;
        in_window   = !below_base && under_count && under_depth;
        idx         = full_idx[IDX_W-1:0];
    end

endmodule

// File: rtl/dma_xlate_ram.sv
// Single-port-read, single-port-write table storage with a one-cycle read.
// The read data register only updates when a read is issued.
// Assumes: a write and a read of the same index never fall in one cycle.
module dma_xlate_ram #(
    parameter int DEPTH   = 256,
    parameter int ENTRY_W = 64,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic               re,
    input  logic [IDX_W-1:0]   ridx,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Store a table entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Registered read of the addressed entry.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[ridx];
        end
    end

endmodule

// File: rtl/dma_xlate_perm.sv
// Entry decode (combinational): clears the page-offset bits of the entry,
// extracts the permission code and tests the requested access against it.
// Assumes: page_mask is contiguous ones from some bit upward.
module dma_xlate_perm
    import dma_xlate_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] page_mask,
    input  logic [1:0]        acc,
    output logic [ADDR_W-1:0] xaddr,
    output perm_e             perm,
    output logic              allow
);

    // Page frame, permission code and coverage test.
    always_comb begin
        xaddr = entry & page_mask;
        perm  = perm_e'(entry[1:0]);
        allow = acc_covered(acc, perm);
    end

endmodule

// File: rtl/dma_xlate_lookup.sv
// DMA translation table lookup, two register stages.
// Edge 1 samples the request, configuration and bound result and issues the
// RAM read. Edge 2 registers the decoded response or the no-access response.
// Assumes: table writes do not target an index being read in the same cycle.
module dma_xlate_lookup
    import dma_xlate_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DEPTH  = 256,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]   cfg_entry_count,
    input  logic [ADDR_W-1:0]  cfg_window_base,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_widx,
    input  logic [ADDR_W-1:0]  tbl_wdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_iova,
    output logic [ADDR_W-1:0]  rsp_xaddr,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic [1:0]         rsp_perm,
    output logic               rsp_allow
);

    logic [IDX_W-1:0]  idx;
    logic              in_window;
    logic [ADDR_W-1:0] page_mask;
    logic [ADDR_W-1:0] ram_rdata;

    logic              s1_valid;
    logic              s1_hit;
    logic [ADDR_W-1:0] s1_iova;
    logic [ADDR_W-1:0] s1_pmask;
    logic [1:0]        s1_acc;

    logic [ADDR_W-1:0] dec_xaddr;
    perm_e             dec_perm;
    logic              dec_allow;

    dma_xlate_index #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .SHIFT_W(SHIFT_W)
    ) index_i (
        .addr       (req_addr),
        .win_base   (cfg_window_base),
        .page_shift (cfg_page_shift),
        .entry_count(cfg_entry_count),
        .idx        (idx),
        .in_window  (in_window),
        .page_mask  (page_mask)
    );

    dma_xlate_ram #(
        .DEPTH  (DEPTH),
        .ENTRY_W(ADDR_W),
        .IDX_W  (IDX_W)
    ) ram_i (
        .clk  (clk),
        .we   (tbl_we),
        .widx (tbl_widx),
        .wdata(tbl_wdata),
        .re   (req_valid && in_window),
        .ridx (idx),
        .rdata(ram_rdata)
    );

    // Stage 1 control: a request is in flight while the RAM read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s1_hit   <= req_valid && in_window;
        end
    end

    // Stage 1 data: request fields that the decode needs one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_iova  <= '0;
            s1_pmask <= '0;
            s1_acc   <= '0;
        end else if (req_valid) begin
            s1_iova  <= req_addr & page_mask;
            s1_pmask <= page_mask;
            s1_acc   <= req_acc;
        end
    end

    dma_xlate_perm #(
        .ADDR_W(ADDR_W)
    ) perm_i (
        .entry    (ram_rdata),
        .page_mask(s1_pmask),
        .acc      (s1_acc),
        .xaddr    (dec_xaddr),
        .perm     (dec_perm),
        .allow    (dec_allow)
    );

    // Response register: decoded hit, or the fixed no-access result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_iova  <= '0;
            rsp_xaddr <= '0;
            rsp_mask  <= '0;
            rsp_perm  <= PERM_NONE;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid && s1_hit) begin
                rsp_iova  <= s1_iova;
                rsp_xaddr <= dec_xaddr;
                rsp_mask  <= ~s1_pmask;
                rsp_perm  <= dec_perm;
                rsp_allow <= dec_allow;
            end else if (s1_valid) begin
                rsp_iova  <= '0;
                rsp_xaddr <= '0;
                rsp_mask  <= '1;
                rsp_perm  <= PERM_NONE;
                rsp_allow <= 1'b0;
            end
        end
    end

    // R2
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid);

    // R7
    miss_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_hit) |=> (rsp_mask == '1 && rsp_xaddr == '0 &&
                                   rsp_iova == '0 && rsp_perm == PERM_NONE && !rsp_allow));

    // R6
    allow_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> (rsp_perm != PERM_NONE));

    // R4
    offset_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_mask & (rsp_mask + ADDR_W'(1))) == '0) &&
                       ((rsp_iova & rsp_mask) == '0) && ((rsp_xaddr & rsp_mask) == '0)));

    // R8
    disabled_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_entry_count == '0) |=> ##1 (rsp_valid && !rsp_allow &&
                                                      rsp_perm == PERM_NONE));

endmodule

// File: tb/dma_xlate_lookup_tb_top.sv
`timescale 1ns/1ps
module dma_xlate_lookup_tb_top;

    typedef struct packed {
        logic [5:0]  sh;
        logic [8:0]  cnt;
        logic [63:0] base;
        logic [63:0] addr;
        logic [1:0]  acc;
    } vec_t;

    localparam int NV = 17;
    // Vector table: shift, count, base, address, access.
    localparam vec_t VECS [NV] = '{
        '{6'd12, 9'd16,  64'h0,          64'h0000,        2'd1}, // idx0 perm0, R5 R6
        '{6'd12, 9'd16,  64'h0,          64'h1234,        2'd1}, // idx1 RO read
        '{6'd12, 9'd16,  64'h0,          64'h1234,        2'd2}, // RO write denied
        '{6'd12, 9'd16,  64'h0,          64'h2FFF,        2'd2}, // idx2 WO write
        '{6'd12, 9'd16,  64'h0,          64'h2FFF,        2'd3}, // WO rw denied
        '{6'd12, 9'd16,  64'h0,          64'h3008,        2'd3}, // idx3 RW
        '{6'd12, 9'd16,  64'h0,          64'h3008,        2'd0}, // empty request
        '{6'd12, 9'd16,  64'h0,          64'h6000,        2'd2}, // idx6 WO
        '{6'd12, 9'd16,  64'h0,          64'hF000,        2'd3}, // last live index
        '{6'd12, 9'd16,  64'h0,          64'h10000,       2'd1}, // one past count, R7
        '{6'd12, 9'd16,  64'h4000_0000,  64'h4000_5123,   2'd1}, // base offset idx5
        '{6'd12, 9'd16,  64'h4000_0000,  64'h3FFF_F000,   2'd1}, // below base, R7
        '{6'd16, 9'd8,   64'h0,          64'h3_ABCD,      2'd1}, // 64 KiB pages idx3
        '{6'd21, 9'd4,   64'h8000_0000,  64'h8060_0010,   2'd2}, // 2 MiB pages idx3
        '{6'd12, 9'd0,   64'h0,          64'h1000,        2'd1}, // disabled, R8
        '{6'd12, 9'd300, 64'h0,          64'hFF000,       2'd3}, // idx255, R10
        '{6'd12, 9'd300, 64'h0,          64'h100000,      2'd3}  // idx256, R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_page_shift = 6'd12;
    logic [8:0]  cfg_entry_count = 9'd0;
    logic [63:0] cfg_window_base = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_widx = '0;
    logic [63:0] tbl_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [63:0] rsp_iova;
    logic [63:0] rsp_xaddr;
    logic [63:0] rsp_mask;
    logic [1:0]  rsp_perm;
    logic        rsp_allow;

    int total = 0;
    int bad = 0;
    logic [63:0] shadow [256];

    always #4 clk = ~clk;

    dma_xlate_lookup dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_page_shift(cfg_page_shift), .cfg_entry_count(cfg_entry_count),
        .cfg_window_base(cfg_window_base),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_xaddr(rsp_xaddr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_allow(rsp_allow)
    );

    function automatic logic [63:0] ent(int i);
        return 64'h80_0000_0000 | (64'(i) << 16) | 64'hA5C | 64'(i % 4);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic write_entry(input int i, input logic [63:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_widx = 8'(i); tbl_wdata = v;
        shadow[i] = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Reference model built from the requirements, then a full compare.
    task automatic lookup(input vec_t v);
        logic [63:0] off, fidx, pm, e, x_iova, x_xa, x_mask;
        logic [1:0]  x_perm;
        logic        hit, x_allow;
        string       tg;
        off  = v.addr - v.base;
        fidx = off >> v.sh;
        hit  = (v.addr >= v.base) && (fidx < 64'(v.cnt)) && (fidx < 64'd256);
        pm   = ~((64'd1 << v.sh) - 64'd1);
        if (hit) begin
            e = shadow[fidx[7:0]];
            x_iova = v.addr & pm; x_xa = e & pm; x_mask = ~pm; x_perm = e[1:0];
            x_allow = (v.acc != 2'd0) && ((v.acc & ~x_perm) == 2'd0);
        end else begin
            x_iova = '0; x_xa = '0; x_mask = '1; x_perm = 2'd0; x_allow = 1'b0;
        end
        @(negedge clk);
        cfg_page_shift = v.sh; cfg_entry_count = v.cnt; cfg_window_base = v.base;
        req_valid = 1'b1; req_addr = v.addr; req_acc = v.acc;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        tg = hit ? "" : (v.cnt == 9'd0 ? "R8" : "R7");
        check("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        check(hit ? "R4" : tg, "rsp_iova", rsp_iova, x_iova);
        check(hit ? "R3" : tg, "rsp_xaddr", rsp_xaddr, x_xa);
        check(hit ? "R4" : tg, "rsp_mask", rsp_mask, x_mask);
        check(hit ? "R5" : tg, "rsp_perm", 64'(rsp_perm), 64'(x_perm));
        check(hit ? "R6" : tg, "rsp_allow", 64'(rsp_allow), 64'(x_allow));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset state, with a request held during reset.
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "rsp_xaddr", rsp_xaddr, 64'd0);
        check("R1", "rsp_mask", rsp_mask, 64'd0);
        check("R1", "rsp_allow", 64'(rsp_allow), 64'd0);
        @(negedge clk);
        check("R1", "rsp_valid later", 64'(rsp_valid), 64'd0);

        // R9: fill the table through the write port.
        for (int i = 0; i < 256; i++) write_entry(i, ent(i));

        for (int k = 0; k < NV; k++) lookup(VECS[k]);

        // R2: back-to-back requests and the gap after them.
        @(negedge clk);
        cfg_page_shift = 6'd12; cfg_entry_count = 9'd16; cfg_window_base = '0;
        req_valid = 1'b1; req_addr = 64'h1000; req_acc = 2'd1;
        @(negedge clk);
        check("R2", "no early valid", 64'(rsp_valid), 64'd0);
        req_addr = 64'h5000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "first valid", 64'(rsp_valid), 64'd1);
        check("R2", "first xaddr", rsp_xaddr, ent(1) & ~64'hFFF);
        @(negedge clk);
        check("R2", "second valid", 64'(rsp_valid), 64'd1);
        check("R2", "second xaddr", rsp_xaddr, ent(5) & ~64'hFFF);
        @(negedge clk);
        check("R2", "gap valid", 64'(rsp_valid), 64'd0);

        // R9: overwrite a live entry twice.
        write_entry(7, 64'h1234_5FF1);
        write_entry(7, 64'h0ABC_D003);
        lookup('{6'd12, 9'd16, 64'h0, 64'h7010, 2'd3});
        check("R9", "overwritten xaddr", rsp_xaddr, 64'h0ABC_D000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule